// File: doc/BRIEF.md
# IOTLB Page-Selective Invalidation Engine

This block is a small, fully associative cache of DMA address translations together with an engine that removes cached entries on request. Each entry holds a DMA page number, a translated page number, a leaf/non-leaf flag, a super-page flag and a valid bit. Software first writes a 64-bit request word that carries a page address, a mask count and a hint. It then pulses a separate command strobe. The engine visits every entry, one per clock. It clears each entry that lies in the size-aligned power-of-two page region the request names, and then pulses a done output.

The mask count N drops the N lowest page-number bits from the match, so one request covers 2^N aligned pages. The hint decides whether cached non-leaf (directory) entries in that region survive. A fill port loads entries and a lookup port translates pages, so the cache can be exercised from the outside. Lookups wait while a walk is running, so they never return a translation that is about to be removed.

Top module: `iotlb_inv_engine`

## Requirements
- R1: After reset every entry is invalid, `busy`, `invDone` and `maskErr` are 0, and `capMaxMask` shows the parameter MAX_MASK (default 9).
- R2: The request word places the page number in bits 38:12, the hint in bit 6 and the mask count in bits 5:0. Writing it changes no cached entry until `invCmd` is pulsed.
- R3: A command seen while idle raises `busy` for exactly NUM_ENTRIES cycles, one entry checked per cycle. `invDone` is high for one cycle, in the first cycle with `busy` low again. Commands seen while busy are ignored.
- R4: A mask count N clears valid entries whose page numbers match the request in every bit except the lowest N, which covers 2^N aligned pages. N = 0 clears one page only.
- R5: With hint 0 the region's leaf and non-leaf entries are both cleared. With hint 1 only leaf entries are cleared and non-leaf entries stay valid.
- R6: Address bits at or above MGAW (default 36, so page bits 26:24) are ignored in both request and entry pages when matching.
- R7: A super-page entry spans 2^9 aligned pages. An invalidation clears it whenever the request region overlaps it, and a lookup of any page inside it hits and returns the translated base with the low 9 page bits taken from the lookup page.
- R8: A mask count above MAX_MASK is clamped to MAX_MASK, and `maskErr` is set and stays set until reset.
- R9: While `busy` is high a lookup is not acknowledged (`lkAck` = 0, `lkHit` = 0). It is answered once the walk is over.
- R10: Fill strobes and request-word writes that arrive while `busy` is high are ignored.
- R11: An acknowledged lookup hits when a valid entry matches. It returns the translation of the lowest-indexed matching entry. On a miss `lkHit` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reqWrEn | input | 1 | Write strobe for the request word |
| reqWrData | input | 64 | Request word: page 38:12, hint 6, mask 5:0 |
| invCmd | input | 1 | Start a page-selective invalidation |
| busy | output | 1 | Walk in progress |
| invDone | output | 1 | One-cycle pulse when the walk has finished |
| maskErr | output | 1 | Sticky flag: a mask count was clamped |
| capMaxMask | output | 6 | Largest supported mask count |
| fillEn | input | 1 | Write an entry |
| fillIdx | input | IDX_W | Entry slot to write |
| fillPage | input | PAGE_W | DMA page number |
| fillXlat | input | PAGE_W | Translated page number |
| fillLeaf | input | 1 | 1 = leaf entry, 0 = non-leaf |
| fillSuper | input | 1 | 1 = 2^9-page super-page entry |
| lkReq | input | 1 | Lookup request |
| lkPage | input | PAGE_W | Page to translate |
| lkAck | output | 1 | Lookup answered this cycle |
| lkHit | output | 1 | Lookup found an entry |
| lkXlat | output | PAGE_W | Translated page number |

## Verification
The hardest case to reach from the ports is a walk that overlaps other traffic: lookups, fills, request rewrites and repeated commands that arrive in the middle of the entry scan. The bench starts a walk and then drives all of these in the following cycles. It then reads the whole cache back through lookups and compares it with a bench model. Random runs use a narrow page space and mask counts on both sides of the clamp. Super-page and non-leaf entries therefore meet requests that overlap them partly, contain them or miss them by one bit.

// File: rtl/iotlb_inv_pkg.sv
package iotlb_inv_pkg;
  localparam int REQ_W    = 64;
  localparam int PAGE_LO  = 12;
  localparam int PAGE_HI  = 38;
  localparam int HINT_BIT = 6;
  localparam int MASK_W   = 6;

  typedef struct packed {
    logic loadReq;
    logic checkEn;
    logic fillOk;
  } ctrlStrobe_t;
endpackage

// File: rtl/iotlb_inv_ctrl.sv
module iotlb_inv_ctrl
  import iotlb_inv_pkg::*;
#(
  parameter int NUM_ENTRIES = 8,
  localparam int IDX_W = $clog2(NUM_ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             invCmd,
  input  logic             reqWrEn,
  input  logic             fillEn,
  output ctrlStrobe_t      strb,
  output logic [IDX_W-1:0] walkIdx,
  output logic             busy,
  output logic             done
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_ENTRIES - 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      done    <= 1'b0;
      walkIdx <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (invCmd) begin
          busy    <= 1'b1;
          walkIdx <= '0;
        end
      end else if (walkIdx == LAST_IDX) begin
        busy <= 1'b0;
        done <= 1'b1;
      end else begin
        walkIdx <= walkIdx + 1'b1;
      end
    end
  end

  always_comb begin
    strb.loadReq = reqWrEn & ~busy;
    strb.checkEn = busy;
    strb.fillOk  = fillEn & ~busy;
  end
endmodule

// File: rtl/iotlb_inv_data.sv
module iotlb_inv_data
  import iotlb_inv_pkg::*;
#(
  parameter int NUM_ENTRIES = 8,
  parameter int PAGE_W      = 27,
  parameter int MGAW        = 36,
  parameter int MAX_MASK    = 9,
  parameter int SUPER_BITS  = 9,
  localparam int IDX_W = $clog2(NUM_ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ctrlStrobe_t       strb,
  input  logic [IDX_W-1:0]  walkIdx,
  input  logic [REQ_W-1:0]  reqWrData,
  input  logic [IDX_W-1:0]  fillIdx,
  input  logic [PAGE_W-1:0] fillPage,
  input  logic [PAGE_W-1:0] fillXlat,
  input  logic              fillLeaf,
  input  logic              fillSuper,
  input  logic [PAGE_W-1:0] lkPage,
  output logic              lkMatch,
  output logic [PAGE_W-1:0] lkXlat,
  output logic              maskErr
);
  localparam logic [MASK_W-1:0] MAX_M   = MASK_W'(MAX_MASK);
  localparam logic [MASK_W-1:0] SUPER_M = MASK_W'(SUPER_BITS);

  function automatic logic [PAGE_W-1:0] careBits(input logic [MASK_W-1:0] low);
    logic [PAGE_W-1:0] b;
    for (int i = 0; i < PAGE_W; i++)
      b[i] = (i >= int'(low)) && (PAGE_LO + i < MGAW);
    return b;
  endfunction

  localparam logic [PAGE_W-1:0] SUP_OFS = ~careBits(SUPER_M) & careBits('0);

  logic [PAGE_W-1:0] reqPage;
  logic [MASK_W-1:0] reqMask;
  logic              reqHint;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reqPage <= '0;
      reqMask <= '0;
      reqHint <= 1'b0;
      maskErr <= 1'b0;
    end else if (strb.loadReq) begin
      reqPage <= reqWrData[PAGE_HI:PAGE_LO];
      reqHint <= reqWrData[HINT_BIT];
      if (reqWrData[MASK_W-1:0] > MAX_M) begin
        reqMask <= MAX_M;
        maskErr <= 1'b1;
      end else begin
        reqMask <= reqWrData[MASK_W-1:0];
      end
    end
  end

  logic [NUM_ENTRIES-1:0] eVld, eLeaf, eSup, lkHitVec;
  logic [PAGE_W-1:0]      ePage [NUM_ENTRIES];
  logic [PAGE_W-1:0]      eXlat [NUM_ENTRIES];

  // single shared comparator for the walk
  logic [MASK_W-1:0] effLow;
  logic              walkHit;
  always_comb begin
    effLow  = (eSup[walkIdx] && reqMask < SUPER_M) ? SUPER_M : reqMask;
    walkHit = eVld[walkIdx]
              && (((ePage[walkIdx] ^ reqPage) & careBits(effLow)) == '0)
              && (!reqHint || eLeaf[walkIdx]);
  end

  for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_entry
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        eVld[g]  <= 1'b0;
        eLeaf[g] <= 1'b0;
        eSup[g]  <= 1'b0;
        ePage[g] <= '0;
        eXlat[g] <= '0;
      end else if (strb.fillOk && fillIdx == IDX_W'(g)) begin
        eVld[g]  <= 1'b1;
        eLeaf[g] <= fillLeaf;
        eSup[g]  <= fillSuper;
        ePage[g] <= fillPage;
        eXlat[g] <= fillXlat;
      end else if (strb.checkEn && walkIdx == IDX_W'(g) && walkHit) begin
        eVld[g] <= 1'b0;
      end
    end

    assign lkHitVec[g] = eVld[g] &&
      (((ePage[g] ^ lkPage) & careBits(eSup[g] ? SUPER_M : '0)) == '0);
  end

  always_comb begin
    lkXlat = '0;
    for (int i = NUM_ENTRIES - 1; i >= 0; i--)
      if (lkHitVec[i])
        lkXlat = eSup[i] ? ((eXlat[i] & ~SUP_OFS) | (lkPage & SUP_OFS)) : eXlat[i];
  end
  assign lkMatch = |lkHitVec;
endmodule

// File: rtl/iotlb_inv_engine.sv
module iotlb_inv_engine
  import iotlb_inv_pkg::*;
#(
  parameter int NUM_ENTRIES = 8,
  parameter int PAGE_W      = 27,
  parameter int MGAW        = 36,
  parameter int MAX_MASK    = 9,
  parameter int SUPER_BITS  = 9,
  localparam int IDX_W = $clog2(NUM_ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reqWrEn,
  input  logic [63:0]       reqWrData,
  input  logic              invCmd,
  output logic              busy,
  output logic              invDone,
  output logic              maskErr,
  output logic [5:0]        capMaxMask,
  input  logic              fillEn,
  input  logic [IDX_W-1:0]  fillIdx,
  input  logic [PAGE_W-1:0] fillPage,
  input  logic [PAGE_W-1:0] fillXlat,
  input  logic              fillLeaf,
  input  logic              fillSuper,
  input  logic              lkReq,
  input  logic [PAGE_W-1:0] lkPage,
  output logic              lkAck,
  output logic              lkHit,
  output logic [PAGE_W-1:0] lkXlat
);
  ctrlStrobe_t      strb;
  logic [IDX_W-1:0] walkIdx;
  logic             lkMatch;

  iotlb_inv_ctrl #(.NUM_ENTRIES(NUM_ENTRIES)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .invCmd(invCmd), .reqWrEn(reqWrEn),
    .fillEn(fillEn), .strb(strb), .walkIdx(walkIdx), .busy(busy), .done(invDone)
  );

  iotlb_inv_data #(
    .NUM_ENTRIES(NUM_ENTRIES), .PAGE_W(PAGE_W), .MGAW(MGAW),
    .MAX_MASK(MAX_MASK), .SUPER_BITS(SUPER_BITS)
  ) u_data (
    .clk(clk), .rst_n(rst_n), .strb(strb), .walkIdx(walkIdx),
    .reqWrData(reqWrData), .fillIdx(fillIdx), .fillPage(fillPage),
    .fillXlat(fillXlat), .fillLeaf(fillLeaf), .fillSuper(fillSuper),
    .lkPage(lkPage), .lkMatch(lkMatch), .lkXlat(lkXlat), .maskErr(maskErr)
  );

  assign capMaxMask = 6'(MAX_MASK);
  assign lkAck      = lkReq & ~busy;
  assign lkHit      = lkAck & lkMatch;
endmodule

// File: rtl/iotlb_inv_chk.sv
module iotlb_inv_chk #(
  parameter int NUM_ENTRIES = 8
) (
  input logic clk,
  input logic rst_n,
  input logic invCmd,
  input logic busy,
  input logic invDone,
  input logic maskErr,
  input logic lkReq,
  input logic lkAck,
  input logic lkHit
);
  int busyCnt;
  always_ff @(posedge clk) begin
    if (!rst_n || !busy) busyCnt <= 0;
    else                 busyCnt <= busyCnt + 1;
  end

  // R3
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    invDone |=> !invDone);
  // R3
  done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    invDone |-> (!busy && $past(busy)));
  // R3
  cmd_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && invCmd) |=> busy);
  // R3
  walk_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    invDone |-> busyCnt == NUM_ENTRIES);
  // R9
  lk_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lkReq && busy) |-> (!lkAck && !lkHit));
  // R11
  hit_needs_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lkHit |-> lkAck);
  // R8
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    maskErr |=> maskErr);
endmodule

bind iotlb_inv_engine iotlb_inv_chk #(.NUM_ENTRIES(NUM_ENTRIES)) u_chk (
  .clk(clk), .rst_n(rst_n), .invCmd(invCmd), .busy(busy), .invDone(invDone),
  .maskErr(maskErr), .lkReq(lkReq), .lkAck(lkAck), .lkHit(lkHit)
);

// File: tb/test_iotlb_inv_engine.sv
module test_iotlb_inv_engine;
  localparam int N  = 8;
  localparam int PW = 27;
  localparam int IW = 3;
  localparam logic [PW-1:0] VA  = 27'h0FF_FFFF;   // page bits below MGAW 36
  localparam logic [PW-1:0] OFS = 27'h1FF;         // super-page offset bits

  logic clk = 0, rst_n = 0;
  logic reqWrEn = 0, invCmd = 0, fillEn = 0, fillLeaf = 0, fillSuper = 0, lkReq = 0;
  logic [63:0] reqWrData = '0;
  logic [IW-1:0] fillIdx = '0;
  logic [PW-1:0] fillPage = '0, fillXlat = '0, lkPage = '0;
  logic busy, invDone, maskErr, lkAck, lkHit;
  logic [5:0] capMaxMask;
  logic [PW-1:0] lkXlat;

  always #10 clk = ~clk;

  iotlb_inv_engine i_iotlb_inv_engine (.*);

  int nChk = 0, nErr = 0;
  logic mV [N], mL [N], mS [N];
  logic [PW-1:0] mP [N], mX [N];
  logic [PW-1:0] rPage; logic [5:0] rMask; logic rHint;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    nChk++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [PW-1:0] care(input int low);
    logic [PW-1:0] b = '0;
    for (int i = low; i < PW; i++) b[i] = 1'b1;
    return b & VA;
  endfunction

  task automatic fill(input int idx, input logic [PW-1:0] p, input logic [PW-1:0] x,
                      input logic lf, input logic sp);
    @(negedge clk);
    fillEn = 1; fillIdx = IW'(idx); fillPage = p; fillXlat = x; fillLeaf = lf; fillSuper = sp;
    @(negedge clk); fillEn = 0;
    mV[idx] = 1; mL[idx] = lf; mS[idx] = sp; mP[idx] = p; mX[idx] = x;
  endtask

  task automatic writeReq(input logic [PW-1:0] p, input int m, input logic h);
    @(negedge clk);
    reqWrEn = 1; reqWrData = {25'h0, p, 5'h0, h, 6'(m)};
    @(negedge clk); reqWrEn = 0;
    rPage = p; rMask = (m > 9) ? 6'd9 : 6'(m); rHint = h;
  endtask

  task automatic runInv();
    int cnt = 0;
    @(negedge clk); invCmd = 1;
    @(negedge clk); invCmd = 0;
    check("R3 busy after command", busy, 1);
    while (!invDone && cnt < 100) begin @(negedge clk); cnt++; end
    check("R3 walk length", cnt, N);
    check("R3 busy low at done", busy, 0);
    @(negedge clk);
    check("R3 done single pulse", invDone, 0);
    for (int i = 0; i < N; i++) begin
      int low = (mS[i] && rMask < 9) ? 9 : int'(rMask);
      if (mV[i] && ((mP[i] ^ rPage) & care(low)) == 0 && (!rHint || mL[i])) mV[i] = 0;
    end
  endtask

  task automatic lookup(input string req, input logic [PW-1:0] p);
    int j = -1;
    logic [PW-1:0] ex = '0;
    for (int i = N - 1; i >= 0; i--)
      if (mV[i] && ((mP[i] ^ p) & care(mS[i] ? 9 : 0)) == 0) j = i;
    if (j >= 0) ex = mS[j] ? ((mX[j] & ~OFS) | (p & OFS)) : mX[j];
    lkReq = 1; lkPage = p; #1;
    check({req, " ack"}, lkAck, 1);
    check({req, " hit"}, lkHit, j >= 0);
    if (j >= 0) check({req, " xlat"}, lkXlat, ex);
    lkReq = 0;
  endtask

  task automatic checkAll(input string req);
    @(negedge clk);
    for (int i = 0; i < N; i++)
      if (mP[i] !== 'x) lookup(req, mP[i] ^ (mS[i] ? ($urandom & OFS) : '0));
  endtask

  initial begin
    #(200000 * 20);
    nErr++; nChk++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nErr);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < N; i++) begin mV[i] = 0; mL[i] = 0; mS[i] = 0; mP[i] = 'x; mX[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check("R1 busy", busy, 0); check("R1 done", invDone, 0);
    check("R1 err", maskErr, 0); check("R1 cap", capMaxMask, 9);
    lookup("R1 empty", 27'h5);

    // R2 request write alone changes nothing
    fill(0, 27'h100, 27'h7001, 1, 0);
    fill(1, 27'h101, 27'h7002, 1, 0);
    writeReq(27'h100, 0, 0);
    repeat (3) @(negedge clk);
    lookup("R2 no effect before command", 27'h100);
    // R4 mask 0: single page
    runInv();
    lookup("R4 mask0 cleared", 27'h100);
    lookup("R4 mask0 neighbour kept", 27'h101);
    // R4 mask 3: 8 pages
    for (int i = 0; i < N; i++) fill(i, 27'h200 + 27'(i * 3), 27'h900 + 27'(i), 1, 0);
    writeReq(27'h203, 3, 0); runInv();
    checkAll("R4 mask3 region");

    // R5 hint
    fill(0, 27'h40, 27'h11, 0, 0); fill(1, 27'h41, 27'h12, 1, 0);
    writeReq(27'h40, 1, 1); runInv();
    lookup("R5 hint1 keeps non-leaf", 27'h40);
    lookup("R5 hint1 clears leaf", 27'h41);
    writeReq(27'h40, 1, 0); runInv();
    lookup("R5 hint0 clears non-leaf", 27'h40);

    // R6 bits above MGAW ignored
    fill(2, 27'h0_0033, 27'h55, 1, 0);
    writeReq(27'h400_0033, 0, 0); runInv();
    lookup("R6 high bits ignored", 27'h0_0033);

    // R7 super-page
    fill(3, 27'h600, 27'hA00, 1, 1);
    lookup("R7 lookup inside super-page", 27'h6AB);
    writeReq(27'h7F0, 0, 0); runInv();
    lookup("R7 small request clears super-page", 27'h600);

    // R8 clamp
    fill(4, 27'h1000, 27'h1, 1, 0);          // differs in page bit 12 from 0x0000
    fill(5, 27'h0100, 27'h2, 1, 0);          // differs in page bit 8
    writeReq(27'h0, 20, 0);
    check("R8 err set", maskErr, 1);
    runInv();
    lookup("R8 clamped mask keeps far page", 27'h1000);
    lookup("R8 clamped mask clears near page", 27'h0100);
    writeReq(27'h0, 2, 0);
    check("R8 err sticky", maskErr, 1);

    // R3/R9/R10 traffic during a walk
    fill(6, 27'h3000, 27'h33, 1, 0);
    writeReq(27'h5555, 0, 0);
    @(negedge clk); invCmd = 1;
    @(negedge clk); invCmd = 1;             // ignored second command
    lkReq = 1; lkPage = 27'h3000; #1;
    check("R9 lookup stalled", lkAck, 0);
    check("R9 no hit while busy", lkHit, 0);
    lkReq = 0;
    @(negedge clk); invCmd = 0;
    fillEn = 1; fillIdx = 7; fillPage = 27'h3100; fillXlat = 27'h44; fillLeaf = 1; fillSuper = 0;
    reqWrEn = 1; reqWrData = {25'h0, 27'h3000, 5'h0, 1'b0, 6'd0};
    @(negedge clk); fillEn = 0; reqWrEn = 0;
    while (!invDone) @(negedge clk);
    @(negedge clk);
    check("R3 no second walk", busy, 0);
    for (int i = 0; i < N; i++)
      if (mV[i] && mP[i] == 27'h5555) mV[i] = 0;
    lookup("R10 fill ignored while busy", 27'h3100);
    runInv();                                 // uses the old request
    lookup("R10 request write ignored while busy", 27'h3000);

    // random
    for (int it = 0; it < 150; it++) begin
      int k = $urandom_range(1, 4);
      for (int f = 0; f < k; f++) begin
        logic sp = ($urandom_range(0, 5) == 0);
        logic [PW-1:0] p = PW'($urandom_range(0, 2047)) | (($urandom & 1) ? 27'h200_0000 : 0);
        if (sp) p = p & ~OFS;
        fill($urandom_range(0, N - 1), p, PW'($urandom), $urandom_range(0, 1), sp);
      end
      writeReq(PW'($urandom_range(0, 2047)), $urandom_range(0, 12), $urandom_range(0, 1));
      runInv();
      checkAll("R11 random cache contents");
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nErr);
    $finish;
  end
endmodule